// File: doc/BRIEF.md
# Fractional-Ratio Clock Enable Generator

This block turns a fast system clock into a slower periodic event whose average period is a rational multiple of the source period, `N + num/den` cycles. It is meant for audio-rate clock enables such as a bit clock or master clock derived from an unrelated system oscillator. For example, a 32 MHz source with 2 + 29/48 gives 12.288 MHz on average. A 100 MHz source with 17 + 631/882 gives a serial audio bit rate. At 96 MHz the same 12.288 MHz target takes 7 + 39/48.

Each output period is either `N` or `N+1` source cycles long. A remainder accumulator decides which. At the start of every period the numerator is added to it. If the sum reaches the denominator, that period gets one extra cycle and the denominator is subtracted. No divider is needed, the long-term rate is exact, and the edge placement error never exceeds one source cycle. The block drives two outputs: a one-cycle enable in the last cycle of each period, and a derived clock that is high for the first half of each period.

The settings `N`, `num` and `den` are sampled only when a new period begins. After reset the accumulator and the period counter both start from zero, so the output sequence is repeatable.

Top module: `frac_clk_gen`

## Requirements
- R1: While `rst_n` is low, `tick` and `clk_out` are 0. Reset is released through a two-stage synchroniser and the accumulator starts at 0. The first period therefore ends (`tick` = 1) on the (L0+2)-th rising edge after `rst_n` rises, where L0 is the first period length from R2.
- R2: Each period length L is set when the period starts. If `frac_num < frac_den` and acc + `frac_num` >= `frac_den`, then L = N+1 and acc becomes acc + `frac_num` - `frac_den`. Otherwise L = N and acc becomes acc + `frac_num`.
- R3: With a valid fraction, any `frac_den` consecutive periods after reset total exactly N*`frac_den` + `frac_num` source cycles.
- R4: `tick` is high only in the last cycle of each period. When the following period is 2 or more cycles long, `tick` is 0 in the cycle after it.
- R5: `clk_out` is 1 for the first ceil(L/2) cycles of each period and 0 for the remaining floor(L/2) cycles.
- R6: A change of `int_part`, `frac_num` or `frac_den` during a period does not alter that period's length. It applies from the next period start.
- R7: When `frac_num >= frac_den`, the fraction is ignored and every period is exactly N cycles.
- R8: `int_part` = 0 is treated as N = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_part | input | INT_W | Integer part N of the period ratio |
| frac_num | input | FRAC_W | Numerator of the fractional part |
| frac_den | input | FRAC_W | Denominator of the fractional part |
| tick | output | 1 | One-cycle enable in the last cycle of each period |
| clk_out | output | 1 | Derived clock, high for the first half of each period |

## Verification
The bench builds the block with INT_W = 8 and FRAC_W = 10. This covers integer parts up to 255 and denominators up to 1023, so the 882-step audio ratio runs through a full accumulator cycle of 882 periods and its exact total can be checked. The same widths reach the edge cases:
- a zero integer part, which gives a one-cycle period with `tick` held high;
- a numerator equal to the denominator;
- a numerator above the denominator;
- alternating N and N+1 with a denominator of 2.

// File: rtl/fcg_pkg.sv
`timescale 1ns/1ps
package fcg_pkg;
  // Default widths of the ratio fields
  localparam int DEF_INT_W   = 8;
  localparam int DEF_FRAC_W  = 10;
  // Stages in the reset release synchroniser
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/fcg_phase_acc.sv
`timescale 1ns/1ps
// Remainder accumulator: decides whether the period starting now is stretched.
module fcg_phase_acc #(
  parameter int FRAC_W = fcg_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FRAC_W-1:0] num,
  input  logic [FRAC_W-1:0] den,
  output logic              carry
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  sum_less;
  logic              frac_ok;

  always_comb begin
    sum      = {1'b0, acc_q} + {1'b0, num};
    sum_less = sum - {1'b0, den};
    frac_ok  = (num < den);
    carry    = frac_ok && (sum >= {1'b0, den});
    acc_d    = acc_q;
    if (load && frac_ok) begin
      if (carry) acc_d = sum_less[FRAC_W-1:0];
      else       acc_d = sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (load) acc_q <= acc_d;
  end
endmodule

// File: rtl/fcg_period_timer.sv
`timescale 1ns/1ps
// Period down-counter: loads N (+1 on carry) at each period start.
module fcg_period_timer #(
  parameter int INT_W = fcg_pkg::DEF_INT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] int_part,
  input  logic             carry,
  output logic             load,
  output logic             tick,
  output logic [INT_W:0]   rem_nx,
  output logic [INT_W:0]   len_nx,
  output logic [INT_W:0]   len_cur
);
  localparam int            LEN_W   = INT_W + 1;
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic             run_q;
  logic [LEN_W-1:0] rem_q, len_q, eff_n;

  always_comb begin
    eff_n = (int_part == '0) ? LEN_ONE : {1'b0, int_part};
    load  = !run_q || (rem_q == LEN_ONE);
    tick  = run_q && (rem_q == LEN_ONE);
    if (load) begin
      len_nx = eff_n + LEN_W'(carry);
      rem_nx = len_nx;
    end else begin
      len_nx = len_q;
      rem_nx = rem_q - LEN_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      rem_q <= '0;
      len_q <= '0;
    end else begin
      run_q <= 1'b1;
      rem_q <= rem_nx;
      len_q <= len_nx;
    end
  end

  assign len_cur = len_q;

  // R2: inside a period the counter steps down by one each cycle
  a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && rem_q != LEN_ONE) |=> (rem_q == $past(rem_q) - LEN_ONE));
  // R4: the cycle after a tick starts a fresh, full-length period
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (rem_q == len_q));
  // R6: the length of a running period is held until its end
  a_r6_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick) |=> $stable(len_q));
  // R8: a running period is never empty
  a_r8_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (len_q != '0 && rem_q <= len_q));
endmodule

// File: rtl/fcg_half_duty.sv
`timescale 1ns/1ps
// Registered derived clock: high while more than half the period remains.
module fcg_half_duty #(
  parameter int LEN_W = fcg_pkg::DEF_INT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] rem_nx,
  input  logic [LEN_W-1:0] len_nx,
  input  logic [LEN_W-1:0] len_cur,
  input  logic             tick,
  output logic             clk_out
);
  logic clk_d, clk_q;

  always_comb clk_d = (rem_nx > (len_nx >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_q <= 1'b0;
    else        clk_q <= clk_d;
  end

  assign clk_out = clk_q;

  // R5: every period opens with the clock high
  a_r5_high_first: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> clk_out);
  // R5: the last cycle of a period of two or more cycles is low
  a_r5_low_last: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && len_cur > LEN_W'(1)) |-> !clk_out);
endmodule

// File: rtl/frac_clk_gen.sv
`timescale 1ns/1ps
module frac_clk_gen #(
  parameter int INT_W  = fcg_pkg::DEF_INT_W,
  parameter int FRAC_W = fcg_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  int_part,
  input  logic [FRAC_W-1:0] frac_num,
  input  logic [FRAC_W-1:0] frac_den,
  output logic              tick,
  output logic              clk_out
);
  localparam int SYNC_N = fcg_pkg::SYNC_STAGES;
  localparam int LEN_W  = INT_W + 1;

  logic [SYNC_N-1:0] rs_q;
  logic              core_rst_n;
  logic              load, carry;
  logic [LEN_W-1:0]  rem_nx, len_nx, len_cur;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_N-2:0], 1'b1};
  end
  assign core_rst_n = rs_q[SYNC_N-1];

  fcg_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(core_rst_n), .load(load),
    .num(frac_num), .den(frac_den), .carry(carry));

  fcg_period_timer #(.INT_W(INT_W)) u_timer (
    .clk(clk), .rst_n(core_rst_n), .int_part(int_part), .carry(carry),
    .load(load), .tick(tick), .rem_nx(rem_nx), .len_nx(len_nx),
    .len_cur(len_cur));

  fcg_half_duty #(.LEN_W(LEN_W)) u_duty (
    .clk(clk), .rst_n(core_rst_n), .rem_nx(rem_nx), .len_nx(len_nx),
    .len_cur(len_cur), .tick(tick), .clk_out(clk_out));

  // R1: both outputs stay quiet while reset is applied
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!tick && !clk_out);
    end
  end
endmodule

// File: tb/sim_frac_clk_gen.sv
`timescale 1ns/1ps
module sim_frac_clk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] int_part = '0;
  logic [9:0] frac_num = '0;
  logic [9:0] frac_den = 10'd1;
  logic       tick, clk_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  frac_clk_gen #(.INT_W(8), .FRAC_W(10)) u0 (
    .clk(clk), .rst_n(rst_n), .int_part(int_part), .frac_num(frac_num),
    .frac_den(frac_den), .tick(tick), .clk_out(clk_out));

  localparam int NV = 8;
  localparam int VN  [NV] = '{2,  17,  7,  4, 5, 3, 6, 0};
  localparam int VNUM[NV] = '{29, 631, 39, 1, 0, 5, 9, 0};
  localparam int VDEN[NV] = '{48, 882, 48, 2, 7, 5, 4, 1};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected length of the next period, from R2, R7 and R8
  function automatic int model_len(ref int acc, input int n, input int num, input int den);
    int ne = (n == 0) ? 1 : n;
    if (num < den) begin
      if (acc + num >= den) begin
        acc = acc + num - den;
        return ne + 1;
      end
      acc = acc + num;
    end
    return ne;
  endfunction

  // Count cycles (and clk_out-high cycles) up to and including the next tick
  task automatic measure(output int cnt, output int hi);
    cnt = 0;
    hi  = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (clk_out) hi++;
    end while (!tick && cnt < 4000);
    if (cnt >= 4000) check(1'b0, "watchdog", cnt, 0);
  endtask

  task automatic do_reset(input int n, input int num, input int den);
    @(negedge clk);
    rst_n    = 1'b0;
    int_part = 8'(n);
    frac_num = 10'(num);
    frac_den = 10'(den);
    repeat (3) @(negedge clk);
    check(!tick && !clk_out, "R1 outputs low in reset", {30'd0, tick, clk_out}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int acc, len, cnt, hi, tot, np;
    // Table walk: each vector from reset
    for (int v = 0; v < NV; v++) begin
      do_reset(VN[v], VNUM[v], VDEN[v]);
      acc = 0;
      tot = 0;
      np  = (VNUM[v] < VDEN[v]) ? VDEN[v] : 8;
      for (int p = 0; p < np; p++) begin
        len = model_len(acc, VN[v], VNUM[v], VDEN[v]);
        measure(cnt, hi);
        if (p == 0) begin
          check(cnt == len + 2, "R1 first tick position", cnt, len + 2);
          tot += cnt - 2;
        end else begin
          check(cnt == len, "R2 period length", cnt, len);
          tot += cnt;
        end
        check(hi == (len + 1) / 2, "R5 clk_out high cycles", hi, (len + 1) / 2);
      end
      if (VNUM[v] < VDEN[v])
        check(tot == ((VN[v] == 0) ? 1 : VN[v]) * VDEN[v] + VNUM[v], "R3 exact total",
              tot, ((VN[v] == 0) ? 1 : VN[v]) * VDEN[v] + VNUM[v]);
      else
        check(tot == VN[v] * np, "R7 fraction ignored", tot, VN[v] * np);
      if (VN[v] >= 2) begin
        @(negedge clk);
        check(!tick, "R4 tick one cycle wide", {31'd0, tick}, 0);
      end else begin
        @(negedge clk);
        check(tick, "R8 N=0 gives tick every cycle", {31'd0, tick}, 1);
      end
    end

    // R6: a change inside a period waits for the next period start
    do_reset(4, 0, 1);
    measure(cnt, hi);
    check(cnt == 6, "R1 first tick position", cnt, 6);
    @(negedge clk);
    int_part = 8'd6;
    measure(cnt, hi);
    check(cnt + 1 == 4, "R6 running period unchanged", cnt + 1, 4);
    measure(cnt, hi);
    check(cnt == 6, "R6 new N applied next period", cnt, 6);
    check(hi == 3, "R5 clk_out high cycles after change", hi, 3);

    // R7: numerator equal to denominator never stretches, even after num change
    @(negedge clk);
    frac_num = 10'd3;
    frac_den = 10'd3;
    measure(cnt, hi);
    measure(cnt, hi);
    check(cnt == 6, "R7 num equal den ignored", cnt, 6);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule